// File: doc/BRIEF.md
# Raise-Once Receive Interrupt Generator

This block sits beside a packet receive queue and decides when the host gets an interrupt message. Every packet arrival is a single-cycle strobe. The block counts queue occupancy: an arrival pushes and a consumer strobe pops. When a packet arrives and no interrupt is outstanding, the block emits a one-cycle message strobe and sets an "already raised" marker. While the marker is set, further arrivals produce no message. A whole burst of packets therefore costs the host one notification and not one per packet.

The marker is released in one of two ways. Software can release it with a clear strobe, which stands for a register write. In automatic mode, the marker is also released when the queue drains to empty. The next arrival after a release raises a fresh message, even if the host is still handling the previous one. Every message is a momentary edge-type event and never a held level. A separate enable input gates the message strobe.

Top module: `rx_irq_once`

## Requirements
- R1: After synchronous reset, `msg_o` is 0, `marker_o` is 0 and `occupancy_o` is 0.
- R2: An arrival while `marker_o` is 0 and `irq_en_i` is 1 drives `msg_o` high for exactly the one cycle after the arrival edge and sets `marker_o` at the same edge. `msg_o` is never high except in the cycle after an enabled arrival.
- R3: An arrival while `marker_o` is 1, without a clear in the same cycle, produces no message, and the marker stays 1.
- R4: A `sw_clear_i` strobe with no arrival drives `marker_o` to 0 at the next edge and produces no message by itself.
- R5: When an arrival and `sw_clear_i` fall in the same cycle, the clear applies first. The arrival then raises a new message and `marker_o` remains 1.
- R6: With `auto_clear_i` = 1, `marker_o` goes to 0 at the edge where occupancy becomes 0, and a later arrival raises a new message. With `auto_clear_i` = 0, reaching empty leaves `marker_o` unchanged.
- R7: `occupancy_o` rises by one on an arrival and falls by one on `consume_i`. When both occur together it is unchanged.
- R8: `occupancy_o` saturates at DEPTH, so an arrival when full with no consume leaves it at DEPTH. A `consume_i` at occupancy 0 is ignored.
- R9: With `irq_en_i` = 0, an arrival on a clear marker sets `marker_o` but produces no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arrive_i | input | 1 | Packet arrival strobe (queue push) |
| consume_i | input | 1 | Consumer strobe (queue pop) |
| sw_clear_i | input | 1 | Software marker clear strobe |
| auto_clear_i | input | 1 | Clear mode: 0 means software only, 1 means also clear on empty |
| irq_en_i | input | 1 | Message enable |
| msg_o | output | 1 | One-cycle interrupt message strobe |
| marker_o | output | 1 | Raised marker (interrupt outstanding) |
| occupancy_o | output | $clog2(DEPTH+1) | Queue occupancy count |

## Verification
The bench builds the block with DEPTH = 4. At that depth, four arrivals reach saturation, and the full-queue cases fit in a few cycles: a push when full, and a push and pop together when full. The same depth keeps a complete drain short. A full drain is needed to compare automatic clearing against software-only clearing and to test a pop on an empty queue. The bench exercises both clear modes and the collision of an arrival with a software clear in the same cycle. It also tests the enable gate with the marker clear and with the marker set.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
  typedef enum logic {
    CLR_SW_ONLY  = 1'b0,
    CLR_ON_EMPTY = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/rxirq_occupancy.sv
module rxirq_occupancy #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [CW-1:0] count_o,
  output logic          drained_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop_ok, push_ok;

  always_comb begin
    pop_ok  = pop_i && (cnt_q != '0);
    push_ok = push_i && ((cnt_q != FULL) || pop_ok);
    cnt_d   = cnt_q + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign count_o   = cnt_q;
  // The queue is empty after this edge.
  assign drained_o = (cnt_d == '0);
endmodule

// File: rtl/rxirq_marker.sv
module rxirq_marker
  import rxirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      arrive_i,
  input  logic      sw_clear_i,
  input  clr_mode_e mode_i,
  input  logic      drained_i,
  input  logic      en_i,
  output logic      msg_o,
  output logic      marker_o
);
  logic marker_q, msg_q;
  logic fire, release_m;

  always_comb begin
    // A clear in the same cycle is applied before the arrival is seen.
    fire      = arrive_i && (!marker_q || sw_clear_i);
    release_m = sw_clear_i || ((mode_i == CLR_ON_EMPTY) && drained_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      marker_q <= 1'b0;
      msg_q    <= 1'b0;
    end else begin
      msg_q <= fire && en_i;
      if (fire)           marker_q <= 1'b1;
      else if (release_m) marker_q <= 1'b0;
    end
  end

  assign msg_o    = msg_q;
  assign marker_o = marker_q;
endmodule

// File: rtl/rx_irq_once.sv
module rx_irq_once
  import rxirq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arrive_i,
  input  logic          consume_i,
  input  logic          sw_clear_i,
  input  logic          auto_clear_i,
  input  logic          irq_en_i,
  output logic          msg_o,
  output logic          marker_o,
  output logic [CW-1:0] occupancy_o
);
  logic      drained;
  clr_mode_e mode;

  assign mode = clr_mode_e'(auto_clear_i);

  rxirq_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk       (clk),
    .rst       (rst),
    .push_i    (arrive_i),
    .pop_i     (consume_i),
    .count_o   (occupancy_o),
    .drained_o (drained)
  );

  rxirq_marker u_mark (
    .clk        (clk),
    .rst        (rst),
    .arrive_i   (arrive_i),
    .sw_clear_i (sw_clear_i),
    .mode_i     (mode),
    .drained_i  (drained),
    .en_i       (irq_en_i),
    .msg_o      (msg_o),
    .marker_o   (marker_o)
  );
endmodule

// File: rtl/rx_irq_once_chk.sv
module rx_irq_once_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          arrive_i,
  input logic          consume_i,
  input logic          sw_clear_i,
  input logic          auto_clear_i,
  input logic          irq_en_i,
  input logic          msg_o,
  input logic          marker_o,
  input logic [CW-1:0] occupancy_o
);
  a_r2_msg_needs_arrival: assert property (@(posedge clk) disable iff (rst)
    msg_o |-> ($past(arrive_i) && $past(irq_en_i)));

  a_r2_msg_with_marker: assert property (@(posedge clk) disable iff (rst)
    msg_o |-> marker_o);

  a_r3_no_repeat: assert property (@(posedge clk) disable iff (rst)
    (marker_o && arrive_i && !sw_clear_i) |=> (!msg_o && marker_o));

  a_r4_sw_release: assert property (@(posedge clk) disable iff (rst)
    (sw_clear_i && !arrive_i) |=> (!marker_o && !msg_o));

  a_r6_auto_release: assert property (@(posedge clk) disable iff (rst)
    (auto_clear_i && occupancy_o == CW'(1) && consume_i && !arrive_i) |=> !marker_o);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occupancy_o <= CW'(DEPTH));

  a_r8_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (occupancy_o == '0 && consume_i && !arrive_i) |=> (occupancy_o == '0));
endmodule

bind rx_irq_once rx_irq_once_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .arrive_i(arrive_i), .consume_i(consume_i),
  .sw_clear_i(sw_clear_i), .auto_clear_i(auto_clear_i), .irq_en_i(irq_en_i),
  .msg_o(msg_o), .marker_o(marker_o), .occupancy_o(occupancy_o)
);

// File: tb/rx_irq_once_tb.sv
`timescale 1ns/1ps
module rx_irq_once_tb;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arrive = 1'b0, consume = 1'b0, sw_clr = 1'b0, auto_clr = 1'b0, en = 1'b1;
  logic msg, marker;
  logic [CW-1:0] occ;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  rx_irq_once #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .arrive_i(arrive), .consume_i(consume),
    .sw_clear_i(sw_clr), .auto_clear_i(auto_clr), .irq_en_i(en),
    .msg_o(msg), .marker_o(marker), .occupancy_o(occ)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs at a falling edge; outputs are valid at the next falling edge.
  task automatic cyc(logic a, logic c, logic s);
    arrive = a; consume = c; sw_clr = s;
    @(negedge clk);
    arrive = 1'b0; consume = 1'b0; sw_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 msg", msg, 0);
    check("R1 marker", marker, 0);
    check("R1 occupancy", occ, 0);
  endtask

  task automatic t_first();
    cyc(1, 0, 0);
    check("R2 msg", msg, 1);
    check("R2 marker", marker, 1);
    check("R7 push", occ, 1);
    cyc(0, 0, 0);
    check("R2 one cycle", msg, 0);
  endtask

  task automatic t_burst();
    cyc(1, 0, 0);
    check("R3 second", msg, 0);
    cyc(1, 0, 0);
    check("R3 third", msg, 0);
    check("R3 marker", marker, 1);
    check("R7 occupancy", occ, 3);
  endtask

  task automatic t_sw_clear();
    cyc(0, 0, 1);
    check("R4 marker", marker, 0);
    check("R4 no msg", msg, 0);
    cyc(1, 0, 0);
    check("R2 after clear", msg, 1);
    check("R7 occupancy", occ, 4);
  endtask

  task automatic t_collide();
    cyc(1, 0, 1);
    check("R5 msg", msg, 1);
    check("R5 marker", marker, 1);
    check("R8 saturate", occ, DEPTH);
    cyc(0, 0, 0);
  endtask

  task automatic t_occupancy();
    cyc(1, 1, 0);
    check("R7 push+pop full", occ, DEPTH);
    cyc(0, 1, 0);
    check("R7 pop", occ, DEPTH - 1);
  endtask

  task automatic t_sw_mode_drain();
    auto_clr = 1'b0;
    for (int i = 0; i < DEPTH - 1; i++) cyc(0, 1, 0);
    check("R6 empty", occ, 0);
    check("R6 sw mode keeps marker", marker, 1);
    cyc(0, 1, 0);
    check("R8 pop on empty", occ, 0);
    cyc(1, 0, 0);
    check("R3 no msg after empty", msg, 0);
  endtask

  task automatic t_auto();
    auto_clr = 1'b1;
    cyc(0, 1, 0);
    check("R6 auto occupancy", occ, 0);
    check("R6 auto release", marker, 0);
    cyc(1, 0, 0);
    check("R6 new msg", msg, 1);
    cyc(0, 0, 0);
    auto_clr = 1'b0;
  endtask

  task automatic t_enable();
    cyc(0, 0, 1);
    check("R4 marker", marker, 0);
    en = 1'b0;
    cyc(1, 0, 0);
    check("R9 no msg", msg, 0);
    check("R9 marker", marker, 1);
    en = 1'b1;
    cyc(1, 0, 0);
    check("R9 marker held", msg, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first();
    t_burst();
    t_sw_clear();
    t_collide();
    t_occupancy();
    t_sw_mode_drain();
    t_auto();
    t_enable();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule